// File: doc/BRIEF.md
# 32-Bit Handshake Pairing Logic

This block lets two 16-bit handshake groups behave as a single 32-bit port. When pairing is active, one rising edge on the primary request line marks both halves as holding data. The host then makes two accesses, one to the low-word group and one to the high-word group, in either order. Only the access that clears the last remaining data-ready flag produces a one-cycle pulse on the primary acknowledge line. The secondary request and acknowledge lines play no part while pairing is on.

When pairing is off, either because the mode bit is clear or because any port enable is clear, each group runs its own request/acknowledge pair independently. Each group also has a local reset bit. Asserting both local reset bits together clears the whole pairing sequence so that a fresh 32-bit transfer can start.

Top module: `wide_handshake_pair`

## Requirements
- R1: Pairing is active only when `wideMode` is 1 and every bit of `portEn` is 1. In every other case the two groups behave as described in R8.
- R2: While pairing is active, a rising edge on `reqPrimary` with both flags clear and no local reset asserted sets `readyLo` and `readyHi` together at the next clock edge.
- R3: An access strobe (`accessLo` or `accessHi`) clears its own group's flag at the next clock edge. An access to a group whose flag is already clear has no effect on the flags or on either acknowledge.
- R4: While pairing is active, `ackPrimary` is high for exactly one cycle, starting at the clock edge that follows the access (or the simultaneous pair of accesses) that leaves both flags clear. The order of the two accesses does not matter.
- R5: While pairing is active, `reqSecondary` is ignored and `ackSecondary` stays 0.
- R6: A request edge that arrives while either flag is still set is ignored. It does not re-arm a flag and is not remembered.
- R7: When `localRstLo` and `localRstHi` are both 1, both flags and both acknowledges are 0 after the next edge. No access in that cycle produces an acknowledge, and a new request then starts a fresh pair.
- R8: When pairing is inactive, a rising edge on `reqPrimary` sets `readyLo` and a rising edge on `reqSecondary` sets `readyHi`. `accessLo` on a set flag pulses `ackPrimary` for one cycle, and `accessHi` on a set flag pulses `ackSecondary` for one cycle.
- R9: A single local reset bit clears only its own group's flag and produces no acknowledge in that cycle.
- R10: While `rstN` is 0, both flags and both acknowledges are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wideMode | input | 1 | Requests 32-bit pairing |
| portEn | input | PORT_CNT | Port enable bits; all must be 1 for pairing |
| reqPrimary | input | 1 | External request of the low-word group |
| reqSecondary | input | 1 | External request of the high-word group |
| accessLo | input | 1 | Host read/write strobe to the low-word group |
| accessHi | input | 1 | Host read/write strobe to the high-word group |
| localRstLo | input | 1 | Local reset of the low-word group |
| localRstHi | input | 1 | Local reset of the high-word group |
| readyLo | output | 1 | Low-word data-ready flag |
| readyHi | output | 1 | High-word data-ready flag |
| ackPrimary | output | 1 | External acknowledge of the low-word group |
| ackSecondary | output | 1 | External acknowledge of the high-word group |

## Verification
The pairing function is tried with three access patterns: low word first, high word first, and both words in the same cycle. Any design that keys the acknowledge to one particular group, rather than to the last flag cleared, fails one of these patterns. Requests that arrive while a half is still pending, stray secondary requests and repeated accesses to an already-clear group are mixed into the pairing sequences, which separates real gating from accidental re-arming. The same request and access patterns are then replayed with pairing off and with one port disabled, which shows that the independent per-group path is selected by the full enable condition and not by the mode bit alone.

// File: rtl/wide_pair_pkg.sv
package wide_pair_pkg;
  localparam int GROUP_CNT = 2;
  localparam int LO = 0;
  localparam int HI = 1;

  typedef struct packed {
    logic [GROUP_CNT-1:0] setFlag;
    logic [GROUP_CNT-1:0] clrFlag;
    logic [GROUP_CNT-1:0] ackPulse;
  } pairStrobe_t;
endpackage

// File: rtl/wide_pair_ctrl.sv
module wide_pair_ctrl
  import wide_pair_pkg::*;
#(
  parameter int PORT_CNT = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wideMode,
  input  logic [PORT_CNT-1:0]  portEn,
  input  logic [GROUP_CNT-1:0] reqIn,
  input  logic [GROUP_CNT-1:0] accessIn,
  input  logic [GROUP_CNT-1:0] localRst,
  input  logic [GROUP_CNT-1:0] readyQ,
  output logic                 wideOn,
  output pairStrobe_t          strb
);
  logic [GROUP_CNT-1:0] reqPrev;
  logic [GROUP_CNT-1:0] reqRise;
  logic [GROUP_CNT-1:0] hit;
  logic [GROUP_CNT-1:0] leftClear;
  logic                 anyLocalRst;
  logic                 pairIdle;
  logic                 pairDone;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) reqPrev <= '0;
    else       reqPrev <= reqIn;
  end

  assign wideOn      = wideMode & (&portEn);
  assign anyLocalRst = |localRst;
  assign pairIdle    = ~(|readyQ);

  for (genvar g = 0; g < GROUP_CNT; g++) begin : gGroup
    assign reqRise[g]   = reqIn[g] & ~reqPrev[g];
    assign hit[g]       = accessIn[g] & readyQ[g] & ~localRst[g];
    assign leftClear[g] = ~readyQ[g] | hit[g];
  end

  assign pairDone = (|hit) & (&leftClear) & ~anyLocalRst;

  always_comb begin
    strb = '0;
    for (int g = 0; g < GROUP_CNT; g++) begin
      strb.clrFlag[g] = localRst[g] | hit[g];
    end
    if (wideOn) begin
      strb.setFlag        = {GROUP_CNT{reqRise[LO] & pairIdle & ~anyLocalRst}};
      strb.ackPulse[LO]   = pairDone;
    end else begin
      for (int g = 0; g < GROUP_CNT; g++) begin
        strb.setFlag[g]  = reqRise[g] & ~readyQ[g] & ~localRst[g];
        strb.ackPulse[g] = hit[g];
      end
    end
  end

  AST_NO_REARM: assert property (@(posedge clk) disable iff (!rstN)
    (wideOn && !pairIdle) |-> (strb.setFlag == '0)); // R6
endmodule

// File: rtl/wide_pair_datapath.sv
module wide_pair_datapath
  import wide_pair_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  pairStrobe_t          strb,
  input  logic                 wideOn,
  input  logic [GROUP_CNT-1:0] localRst,
  output logic [GROUP_CNT-1:0] readyQ,
  output logic [GROUP_CNT-1:0] ackQ
);
  for (genvar g = 0; g < GROUP_CNT; g++) begin : gFlag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        readyQ[g] <= 1'b0;
        ackQ[g]   <= 1'b0;
      end else begin
        ackQ[g] <= strb.ackPulse[g];
        if (strb.clrFlag[g])      readyQ[g] <= 1'b0;
        else if (strb.setFlag[g]) readyQ[g] <= 1'b1;
      end
    end

    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
      ackQ[g] |=> !ackQ[g]); // R4
  end

  AST_ACK_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    ackQ[LO] |-> $past(|readyQ)); // R4

  AST_SECONDARY_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    $past(wideOn) |-> !ackQ[HI]); // R5

  AST_PAIR_SET: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(readyQ[LO]) && $past(wideOn)) |-> readyQ[HI]); // R2

  AST_PAIR_RESET: assert property (@(posedge clk) disable iff (!rstN)
    $past(&localRst) |-> (readyQ == '0 && ackQ == '0)); // R7
endmodule

// File: rtl/wide_handshake_pair.sv
module wide_handshake_pair
  import wide_pair_pkg::*;
#(
  parameter int PORT_CNT = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wideMode,
  input  logic [PORT_CNT-1:0] portEn,
  input  logic                reqPrimary,
  input  logic                reqSecondary,
  input  logic                accessLo,
  input  logic                accessHi,
  input  logic                localRstLo,
  input  logic                localRstHi,
  output logic                readyLo,
  output logic                readyHi,
  output logic                ackPrimary,
  output logic                ackSecondary
);
  pairStrobe_t          strb;
  logic                 wideOn;
  logic [GROUP_CNT-1:0] readyQ;
  logic [GROUP_CNT-1:0] ackQ;
  logic [GROUP_CNT-1:0] localRst;

  assign localRst = {localRstHi, localRstLo};

  wide_pair_ctrl #(.PORT_CNT(PORT_CNT)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .wideMode (wideMode),
    .portEn   (portEn),
    .reqIn    ({reqSecondary, reqPrimary}),
    .accessIn ({accessHi, accessLo}),
    .localRst (localRst),
    .readyQ   (readyQ),
    .wideOn   (wideOn),
    .strb     (strb)
  );

  wide_pair_datapath uData (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .wideOn   (wideOn),
    .localRst (localRst),
    .readyQ   (readyQ),
    .ackQ     (ackQ)
  );

  assign readyLo      = readyQ[LO];
  assign readyHi      = readyQ[HI];
  assign ackPrimary   = ackQ[LO];
  assign ackSecondary = ackQ[HI];
endmodule

// File: tb/tb_wide_handshake_pair.sv
`timescale 1ns/1ps
module tb_wide_handshake_pair;
  localparam int PORT_CNT = 4;
  localparam int NVEC = 27;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wideMode = 1'b0;
  logic [PORT_CNT-1:0] portEn = '0;
  logic reqPrimary = 1'b0, reqSecondary = 1'b0;
  logic accessLo = 1'b0, accessHi = 1'b0;
  logic localRstLo = 1'b0, localRstHi = 1'b0;
  logic readyLo, readyHi, ackPrimary, ackSecondary;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  wide_handshake_pair #(.PORT_CNT(PORT_CNT)) dut (
    .clk(clk), .rstN(rstN), .wideMode(wideMode), .portEn(portEn),
    .reqPrimary(reqPrimary), .reqSecondary(reqSecondary),
    .accessLo(accessLo), .accessHi(accessHi),
    .localRstLo(localRstLo), .localRstHi(localRstHi),
    .readyLo(readyLo), .readyHi(readyHi),
    .ackPrimary(ackPrimary), .ackSecondary(ackSecondary)
  );

  // Vector: [18:15] requirement id, [14] wideMode, [13:10] portEn,
  // [9] reqPrimary, [8] reqSecondary, [7] accessLo, [6] accessHi,
  // [5] localRstLo, [4] localRstHi,
  // expected after the edge: [3] readyLo, [2] readyHi, [1] ackPrimary, [0] ackSecondary
  localparam logic [18:0] VEC [NVEC] = '{
    19'b0001_1_1111_00_00_00_0000, // R1 paired idle
    19'b0010_1_1111_10_00_00_1100, // R2 request sets both flags
    19'b0011_1_1111_00_10_00_0100, // R3 low access clears low flag
    19'b0011_1_1111_00_10_00_0100, // R3 access on clear flag ignored
    19'b0110_1_1111_10_00_00_0100, // R6 request while high pending ignored
    19'b0101_1_1111_01_01_00_0010, // R5 secondary request ignored, R4 ack on last flag
    19'b0100_1_1111_00_00_00_0000, // R4 ack lasts one cycle
    19'b0010_1_1111_10_00_00_1100, // R2 second pair
    19'b0011_1_1111_00_01_00_1000, // R3 high word first
    19'b0100_1_1111_00_10_00_0010, // R4 ack after reversed order
    19'b0010_1_1111_10_00_00_1100, // R2 third pair
    19'b0100_1_1111_00_11_00_0010, // R4 both halves in one cycle
    19'b0010_1_1111_10_00_00_1100, // R2 fourth pair
    19'b0111_1_1111_00_00_11_0000, // R7 both local resets clear pair
    19'b0111_1_1111_00_11_00_0000, // R7 accesses after restart give no ack
    19'b0111_1_1111_10_00_00_1100, // R7 fresh pair after restart
    19'b1001_1_1111_00_00_01_1000, // R9 single local reset clears high only
    19'b0100_1_1111_00_10_00_0010, // R4 remaining low flag completes pair
    19'b1000_0_1111_10_00_00_1000, // R8 independent low request
    19'b1000_0_1111_01_00_00_1100, // R8 independent high request
    19'b1000_0_1111_00_10_00_0110, // R8 low access acks primary only
    19'b1000_0_1111_00_01_00_0001, // R8 high access acks secondary
    19'b0001_1_1110_10_00_00_1000, // R1 one port disabled: no pairing
    19'b0001_1_1110_00_10_00_0010, // R1 low access acks alone
    19'b0001_1_1110_01_00_00_0100, // R1 secondary request honoured
    19'b0001_1_1110_00_01_00_0001, // R1 secondary ack
    19'b0001_1_1111_00_00_00_0000  // R1 back to paired idle
  };

  task automatic checkOut(input int reqId, input logic [3:0] exp, input string what);
    logic [3:0] act;
    act = {readyLo, readyHi, ackPrimary, ackSecondary};
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL R%0d %s: actual=%b expected=%b", reqId, what, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    checkOut(10, 4'b0000, "reset state"); // R10
    rstN = 1'b1;
    @(negedge clk);
    checkOut(10, 4'b0000, "after reset release"); // R10

    for (int i = 0; i < NVEC; i++) begin
      wideMode     = VEC[i][14];
      portEn       = VEC[i][13:10];
      reqPrimary   = VEC[i][9];
      reqSecondary = VEC[i][8];
      accessLo     = VEC[i][7];
      accessHi     = VEC[i][6];
      localRstLo   = VEC[i][5];
      localRstHi   = VEC[i][4];
      @(negedge clk);
      checkOut(int'(VEC[i][18:15]), VEC[i][3:0], $sformatf("vector %0d", i));
    end

    // R10: reset in the middle of a pair clears both flags at once
    wideMode = 1'b1; portEn = '1; reqPrimary = 1'b1;
    @(negedge clk);
    checkOut(2, 4'b1100, "pair armed before reset"); // R2
    reqPrimary = 1'b0;
    rstN = 1'b0;
    #1;
    checkOut(10, 4'b0000, "asynchronous reset mid-pair"); // R10
    @(negedge clk);
    rstN = 1'b1;
    accessLo = 1'b1; accessHi = 1'b1;
    @(negedge clk);
    checkOut(3, 4'b0000, "accesses after reset give no ack"); // R3
    accessLo = 1'b0; accessHi = 1'b0;

    // R6: a request held high through completion does not re-arm
    reqPrimary = 1'b1;
    @(negedge clk);
    accessLo = 1'b1; accessHi = 1'b1;
    @(negedge clk);
    checkOut(4, 4'b0010, "completion with request held"); // R4
    accessLo = 1'b0; accessHi = 1'b0;
    @(negedge clk);
    checkOut(6, 4'b0000, "held request not re-counted"); // R6
    reqPrimary = 1'b0;
    @(negedge clk);

    finishRun();
  end
endmodule